// File: doc/BRIEF.md
# Alarm Interrupt and Square-Wave Pin Controller

This block sits between a real-time clock's alarm comparators and its two open-drain style output pins. It keeps one 8-bit control register, written through a simple strobe-and-data port and read back in parallel. From that register it produces an oscillator run enable, an active-low interrupt A pin, and a second pin that either carries a divided square wave or serves as a dedicated active-low interrupt B pin.

The square wave comes from a free-running tick counter advanced by a 32.768 kHz clock enable. The counter only moves while the oscillator is running, so stopping the oscillator freezes the wave. A single interrupt-routing bit decides the pin roles. When it is set, alarm 1 drives pin A and alarm 2 drives pin B, and no square wave appears. When it is clear, either enabled alarm drives pin A and pin B carries the square wave.

Top module: `alarm_sqw_ctrl`

## Requirements
- R1: After reset the control readback is 0x1C, the oscillator enable output is 1, and both pins are high.
- R2: A write stores the data with bits 6 and 5 forced to 0, so the readback one cycle later equals the data ANDed with 0x9F. With no write, the register holds its value.
- R3: The oscillator enable output is the inverse of control bit 7 (0 runs, 1 stops).
- R4: With control bit 2 set to 1, interrupt A is low exactly when the alarm 1 flag and control bit 0 are both 1. It follows the flag one clock later.
- R5: With control bit 2 set to 1, pin B is low exactly when the alarm 2 flag and control bit 1 are both 1, and it carries no square wave.
- R6: With control bit 2 set to 0, interrupt A is low when either alarm flag is 1 together with its enable bit, and pin B carries the square wave.
- R7: The tick counter counts 32.768 kHz enables since reset while the oscillator runs. Rate field bits 4:3 = 01 gives pin B the count's bit 2 (period 8 ticks), 10 gives bit 1 (period 4 ticks), and 00 gives bit 14 (period 32768 ticks). The wave reaches pin B two clocks after the tick.
- R8: Rate field 11 puts a one-clock high pulse on pin B for each tick, two clocks after the tick.
- R9: While control bit 7 is 1, ticks are not counted and the wave holds its level. Counting resumes from the held value once the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| tick_32k | input | 1 | One-clock enable at 32.768 kHz |
| alarm1_flag | input | 1 | Alarm 1 match flag |
| alarm2_flag | input | 1 | Alarm 2 match flag |
| ctrl_rdata | output | 8 | Control register readback |
| osc_en | output | 1 | Oscillator run enable, active high |
| int_a_n | output | 1 | Interrupt A pin, active low |
| sqw_int_b_n | output | 1 | Square wave or interrupt B pin |

## Verification
A control write and an alarm flag can land in the same clock edge. The case that matters is alarm 2 rising in the very cycle the routing bit flips. The bench provokes this by driving the strobe and the flag on the same edge, first switching to dedicated-interrupt routing and later back to square-wave routing. It then judges pin B and interrupt A against the new routing once the register stage and the pin stage have both settled.

// File: rtl/alarm_sqw_pkg.sv
package alarm_sqw_pkg;

    typedef struct packed {
        logic       osc_stop;
        logic [1:0] unused;
        logic [1:0] rate;
        logic       route_sep;
        logic       en2;
        logic       en1;
    } ctrl_t;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_MID  = 2'b01,
        RATE_FAST = 2'b10,
        RATE_FULL = 2'b11
    } rate_e;

    localparam logic [7:0] CTRL_RESET = 8'h1C;
    localparam logic [7:0] CTRL_WMASK = 8'h9F;

endpackage

// File: rtl/asc_ctrl_reg.sv
module asc_ctrl_reg
    import alarm_sqw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctrl_t      ctrl
);
    typedef struct packed {
        ctrl_t ctrl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl = ctrl_t'(wr_data & CTRL_WMASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_t'(CTRL_RESET);
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;

    // R2: a write lands masked on the next edge
    assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (8'(ctrl) == ($past(wr_data) & CTRL_WMASK)));

    // R2: without a write the register holds
    assert_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));
endmodule

// File: rtl/asc_divider.sv
module asc_divider
    import alarm_sqw_pkg::*;
#(
    parameter int TICK_HZ = 32768,
    parameter int SLOW_HZ = 1,
    parameter int MID_HZ  = 4096,
    parameter int FAST_HZ = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       wave
);
    localparam int CNT_W    = $clog2(TICK_HZ / SLOW_HZ);
    localparam int SLOW_BIT = CNT_W - 1;
    localparam int MID_BIT  = $clog2(TICK_HZ / MID_HZ) - 1;
    localparam int FAST_BIT = $clog2(TICK_HZ / FAST_HZ) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wave;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (tick) st_d.cnt = st_q.cnt + 1'b1;
            case (rate_e'(rate))
                RATE_SLOW: st_d.wave = st_d.cnt[SLOW_BIT];
                RATE_MID:  st_d.wave = st_d.cnt[MID_BIT];
                RATE_FAST: st_d.wave = st_d.cnt[FAST_BIT];
                default:   st_d.wave = tick;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave = st_q.wave;

    // R9: stopped oscillator freezes counter and wave
    assert_freeze_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(st_q.cnt));
    assert_freeze_wave_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(wave));

    // R7: each counted tick advances the counter by one
    assert_tick_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
endmodule

// File: rtl/asc_pin_router.sv
module asc_pin_router
    import alarm_sqw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  alarm1,
    input  logic  alarm2,
    input  logic  wave,
    output logic  int_a_n,
    output logic  pin_b_n
);
    typedef struct packed {
        logic a_n;
        logic b_n;
    } st_t;

    st_t  st_d, st_q;
    logic hit1, hit2;

    always_comb begin
        hit1 = alarm1 & ctrl.en1;
        hit2 = alarm2 & ctrl.en2;
        st_d = st_q;
        if (ctrl.route_sep) begin
            st_d.a_n = ~hit1;
            st_d.b_n = ~hit2;
        end else begin
            st_d.a_n = ~(hit1 | hit2);
            st_d.b_n = wave;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign int_a_n = st_q.a_n;
    assign pin_b_n = st_q.b_n;

    // R5: separate routing and no alarm 2 keeps pin B high
    assert_b_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.route_sep && !alarm2) |=> pin_b_n);

    // R6: merged routing passes the wave to pin B
    assert_b_wave_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.route_sep |=> (pin_b_n == $past(wave)));

    // R4: with both enables clear interrupt A never asserts
    assert_a_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en1 && !ctrl.en2) |=> int_a_n);

    // R4: separate routing ignores alarm 2 on pin A
    assert_a_sep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.route_sep && !alarm1) |=> int_a_n);
endmodule

// File: rtl/alarm_sqw_ctrl.sv
module alarm_sqw_ctrl
    import alarm_sqw_pkg::*;
#(
    parameter int TICK_HZ = 32768,
    parameter int SLOW_HZ = 1,
    parameter int MID_HZ  = 4096,
    parameter int FAST_HZ = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       tick_32k,
    input  logic       alarm1_flag,
    input  logic       alarm2_flag,
    output logic [7:0] ctrl_rdata,
    output logic       osc_en,
    output logic       int_a_n,
    output logic       sqw_int_b_n
);
    ctrl_t ctrl;
    logic  wave;

    asc_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    asc_divider #(
        .TICK_HZ (TICK_HZ),
        .SLOW_HZ (SLOW_HZ),
        .MID_HZ  (MID_HZ),
        .FAST_HZ (FAST_HZ)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_32k),
        .run   (~ctrl.osc_stop),
        .rate  (ctrl.rate),
        .wave  (wave)
    );

    asc_pin_router u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .alarm1  (alarm1_flag),
        .alarm2  (alarm2_flag),
        .wave    (wave),
        .int_a_n (int_a_n),
        .pin_b_n (sqw_int_b_n)
    );

    assign ctrl_rdata = 8'(ctrl);
    assign osc_en     = ~ctrl.osc_stop;
endmodule

// File: tb/alarm_sqw_ctrl_test.sv
module alarm_sqw_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tick_32k = 1'b0;
    logic       alarm1_flag = 1'b0;
    logic       alarm2_flag = 1'b0;
    logic [7:0] ctrl_rdata;
    logic       osc_en, int_a_n, sqw_int_b_n;

    always #2 clk = ~clk;

    alarm_sqw_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick_32k(tick_32k), .alarm1_flag(alarm1_flag), .alarm2_flag(alarm2_flag),
        .ctrl_rdata(ctrl_rdata), .osc_en(osc_en), .int_a_n(int_a_n),
        .sqw_int_b_n(sqw_int_b_n)
    );

    typedef struct {
        logic [7:0] rd;
        logic       osc;
        logic       a;
        logic       b;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    logic [7:0] m_ctrl = 8'h1C;
    int         m_cnt = 0;

    function automatic logic wave_model(logic pulse);
        case (m_ctrl[4:3])
            2'b00:   return 1'((m_cnt >> 14) & 1);
            2'b01:   return 1'((m_cnt >> 2) & 1);
            2'b10:   return 1'((m_cnt >> 1) & 1);
            default: return pulse;
        endcase
    endfunction

    // driver side: compute expectation from the model and queue it
    task automatic push(string req, logic pulse = 1'b0);
        exp_t e;
        logic h1, h2;
        h1 = alarm1_flag & m_ctrl[0];
        h2 = alarm2_flag & m_ctrl[1];
        e.rd  = m_ctrl;
        e.osc = ~m_ctrl[7];
        if (m_ctrl[2]) begin
            e.a = ~h1;
            e.b = ~h2;
        end else begin
            e.a = ~(h1 | h2);
            e.b = wave_model(pulse);
        end
        e.req = req;
        q.push_back(e);
    endtask

    // monitor side: pop and compare once outputs are settled
    always begin
        @(negedge clk);
        #1;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (ctrl_rdata !== e.rd || osc_en !== e.osc ||
                int_a_n !== e.a || sqw_int_b_n !== e.b) begin
                n_fail++;
                $display("FAIL %s: actual rd=%h osc=%b a=%b b=%b expected rd=%h osc=%b a=%b b=%b",
                         e.req, ctrl_rdata, osc_en, int_a_n, sqw_int_b_n,
                         e.rd, e.osc, e.a, e.b);
            end
        end
    end

    task automatic write_ctrl(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_ctrl = d & 8'h9F;
        @(negedge clk);
    endtask

    task automatic set_flags(logic f1, logic f2);
        @(negedge clk);
        alarm1_flag = f1;
        alarm2_flag = f2;
        @(negedge clk);
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick_32k = 1'b1;
        @(negedge clk);
        tick_32k = 1'b0;
        if (!m_ctrl[7]) m_cnt++;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push("R1 reset state");

        // R2, R3: masked store and oscillator stop
        write_ctrl(8'hFF);
        push("R2 R3 write 0xFF");
        write_ctrl(8'h7F);
        push("R2 R3 write 0x7F");

        // R4, R5: separate routing
        set_flags(1'b1, 1'b0); push("R4 alarm1 on pin A");
        set_flags(1'b0, 1'b1); push("R5 alarm2 on pin B");
        set_flags(1'b1, 1'b1); push("R4 R5 both alarms");
        write_ctrl(8'h1C);     push("R4 R5 enables clear");
        set_flags(1'b0, 1'b0); push("R4 idle");

        // R6: merged routing with square wave
        write_ctrl(8'h0B);
        set_flags(1'b1, 1'b0); push("R6 alarm1 merged");
        set_flags(1'b0, 1'b1); push("R6 alarm2 merged");
        set_flags(1'b0, 1'b0); push("R6 no alarm");

        // R7: rate 01 then rate 10
        for (int i = 0; i < 16; i++) begin
            do_tick(); push("R7 rate 01 wave");
        end
        write_ctrl(8'h13);
        for (int i = 0; i < 8; i++) begin
            do_tick(); push("R7 rate 10 wave");
        end

        // R8: full-rate pulse
        write_ctrl(8'h1B);
        for (int i = 0; i < 3; i++) begin
            do_tick(); push("R8 pulse high", 1'b1);
            @(negedge clk); push("R8 pulse low", 1'b0);
        end

        // R9: freeze while stopped, resume after
        write_ctrl(8'h0B);
        do_tick(); push("R9 before stop");
        write_ctrl(8'h8B);
        for (int i = 0; i < 6; i++) begin
            do_tick(); push("R9 frozen");
        end
        write_ctrl(8'h0B);
        for (int i = 0; i < 5; i++) begin
            do_tick(); push("R9 resumed");
        end

        // coincident write and alarm 2 rise
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h1F; alarm2_flag = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; m_ctrl = 8'h1F;
        @(negedge clk);
        push("R5 coincident route to B");
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h0B;
        @(negedge clk);
        wr_en = 1'b0; m_ctrl = 8'h0B;
        @(negedge clk);
        push("R6 coincident route to wave");
        set_flags(1'b0, 1'b0);

        // R7: 1 Hz rate, bit 14 edge
        write_ctrl(8'h03);
        while (m_cnt < 16383) do_tick();
        push("R7 rate 00 before edge");
        do_tick();
        push("R7 rate 00 at edge");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule